// File: doc/BRIEF.md
# Snooping Shadow Frame Buffer Controller

This block sits beside a host CPU's static RAM and only listens. On every host clock edge where the active-low write strobe is low, it checks the address. A write that lands in the row-indirection table or in one of the pixel pages is captured and handed through a small dual-clock FIFO to the video clock domain. There, a local copy of the indirection table and a pair of pixel buffers are updated. The block never drives the host bus.

In the video domain the block generates its own raster timing. Each displayed line looks up which stored row it shows through the local indirection table. The 120 stored rows are each repeated on four consecutive lines, so they fill a 480-line picture. A control state machine sits in the video domain and is steered in-band. Writing zero to the page byte of indirection entry 0 leaves normal operation. The byte next to it then selects one of these behaviours:
- staging new pixels out of sight;
- flipping to the staged picture;
- ignoring the video area altogether.

States of the control machine are `MS_DEFAULT`, `MS_STORE`, `MS_SHOW` and `MS_BLIND`. A zero page write to entry 0 moves the machine from any state to the state that the stored mode byte decodes to. A mode-byte write while not in `MS_DEFAULT` moves it at once to the decoded state. A non-zero page write to entry 0 moves it from any state back to `MS_DEFAULT`. Every entry into `MS_SHOW` from another state swaps the displayed buffer.

Top module: `snoop_fb_ctrl`

## Requirements
- R1: A host write is captured only on a clock edge where `host_we_n` is 0 and the address is in the table or in a pixel cell. A pixel cell is a page from PAGE0 to PAGE0+119 with a low byte below COLS. Only data bits 5:0 are stored as a pixel.
- R2: The indirection table starts at 0x0100. Entry r has its page byte at 0x0100+2r. Byte 0x0101 is the mode byte. Pixel (row p, column x) lives at address {PAGE0+p, x}, where PAGE0 is 0x08 by default.
- R3: The picture has 480 active lines of COLS pixels each. Active line L shows the row named by table entry floor(L/4), so each stored row appears on four consecutive lines.
- R4: The block generates its own timing with active-high sync pulses. The hsync period is H_TOTAL = COLS+6 video clocks, with a 2-clock pulse. The vsync period is 486 lines, with a 2-line pulse. `vid_de` is never high during either sync.
- R5: During reset, all video outputs are 0. After reset, the state is `MS_DEFAULT` and table entry r holds page PAGE0+r.
- R6: A table entry that holds a page outside the pixel pages shows colour 0 on its four lines.
- R7: Writing 0 to entry 0's page byte enters the state decoded from the mode byte. Code 0x01 decodes to `MS_STORE`, 0x02 to `MS_SHOW`, and any other value to `MS_BLIND`. Entry 0's stored page is left unchanged.
- R8: Outside `MS_DEFAULT`, table page writes other than entry 0 are ignored, and the displayed buffer is not written.
- R9: In `MS_STORE`, pixel writes go to the hidden buffer while the shown picture is held.
- R10: Entering `MS_SHOW` swaps the displayed buffer. Pixel writes in `MS_SHOW` are ignored.
- R11: In `MS_BLIND`, pixel and table writes are ignored. A further zero page write keeps the block out of `MS_DEFAULT`.
- R12: Writing a non-zero page to entry 0 returns the block to `MS_DEFAULT` and stores that page. In `MS_DEFAULT`, pixel and table writes take effect in the displayed picture.
- R13: Captured writes reach the video domain in host order, so the last of two writes to one cell wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host bus clock |
| host_rst_n | input | 1 | Active-low reset, host domain |
| host_addr | input | 16 | Snooped host RAM address |
| host_data | input | 8 | Snooped host write data |
| host_we_n | input | 1 | Snooped active-low write strobe |
| vid_clk | input | 1 | Pixel clock |
| vid_rst_n | input | 1 | Active-low reset, video domain |
| vid_hsync | output | 1 | Horizontal sync, active high |
| vid_vsync | output | 1 | Vertical sync, active high |
| vid_de | output | 1 | Active-area flag |
| vid_pixel | output | 6 | Pixel colour, 0 outside the active area |

## Verification
A wrong control state or a wrong buffer-select bit does not show up at once. It appears in the first full frame after the write that should have changed it, as a picture that is either the stale buffer or one still taking writes. A corrupted table entry shows as exactly four wrong lines in the next frame. A FIFO that loses or reorders writes shows as isolated wrong cells. Frame-wide comparisons therefore catch each of these within one frame period of the write that caused it.

// File: rtl/snoop_fb_pkg.sv
package snoop_fb_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int PIX_W  = 6;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } snoop_word_t;

    typedef enum logic [1:0] {
        MS_DEFAULT,
        MS_STORE,
        MS_SHOW,
        MS_BLIND
    } mode_state_e;

    localparam logic [7:0] MODE_CODE_STORE = 8'h01;
    localparam logic [7:0] MODE_CODE_SHOW  = 8'h02;

    function automatic mode_state_e decode_mode(input logic [7:0] code);
        if (code == MODE_CODE_STORE) return MS_STORE;
        if (code == MODE_CODE_SHOW)  return MS_SHOW;
        return MS_BLIND;
    endfunction
endpackage

// File: rtl/snoop_capture.sv
module snoop_capture
    import snoop_fb_pkg::*;
#(
    parameter logic [15:0] IND_BASE = 16'h0100,
    parameter logic [7:0]  PAGE0    = 8'h08,
    parameter int          ROWS     = 120,
    parameter int          COLS     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              we_n,
    output logic              cap_valid,
    output snoop_word_t       cap_word
);
    localparam logic [16:0] TBL_LO   = {1'b0, IND_BASE};
    localparam logic [16:0] TBL_HI   = TBL_LO + 17'(2 * ROWS);
    localparam logic [8:0]  PAGE_END = 9'(PAGE0) + 9'(ROWS);
    localparam logic [8:0]  COL_LIM  = 9'(COLS);

    logic in_tbl, in_pix;

    always_comb begin
        in_tbl = ({1'b0, addr} >= TBL_LO) && ({1'b0, addr} < TBL_HI);
        in_pix = (addr[15:8] >= PAGE0) && ({1'b0, addr[15:8]} < PAGE_END)
                 && ({1'b0, addr[7:0]} < COL_LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_word  <= '0;
        end else begin
            cap_valid <= !we_n && (in_tbl || in_pix);
            cap_word  <= '{addr: addr, data: data};
        end
    end
endmodule

// File: rtl/snoop_async_fifo.sv
module snoop_async_fifo #(
    parameter int DW = 24,
    parameter int AW = 3
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    output logic          full,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] ONE = 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0] wbin, wgray, rbin, rgray;
    logic [AW:0] rq1, rq2, wq1, wq2;
    logic do_push, do_pop;

    function automatic logic [AW:0] to_gray(input logic [AW:0] b);
        return b ^ (b >> 1);
    endfunction

    assign full    = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
    assign empty   = (rgray == wq2);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rbin[AW-1:0]];

    always_ff @(posedge wclk) begin
        if (do_push) mem[wbin[AW-1:0]] <= wdata;
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin <= '0;
            wgray <= '0;
            rq1 <= '0;
            rq2 <= '0;
        end else begin
            rq1 <= rgray;
            rq2 <= rq1;
            if (do_push) begin
                wbin  <= wbin + ONE;
                wgray <= to_gray(wbin + ONE);
            end
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin <= '0;
            rgray <= '0;
            wq1 <= '0;
            wq2 <= '0;
        end else begin
            wq1 <= wgray;
            wq2 <= wq1;
            if (do_pop) begin
                rbin  <= rbin + ONE;
                rgray <= to_gray(rbin + ONE);
            end
        end
    end

    // R13: the snooped host cannot be stalled, so a push must never meet a full queue
    assert_no_overflow_R13: assert property (@(posedge wclk) disable iff (!wrst_n)
        push |-> !full);
endmodule

// File: rtl/snoop_mode_ctrl.sv
module snoop_mode_ctrl
    import snoop_fb_pkg::*;
#(
    parameter logic [15:0] IND_BASE = 16'h0100,
    parameter logic [7:0]  PAGE0    = 8'h08,
    parameter int          ROWS     = 120,
    parameter int          COLS     = 8,
    localparam int         RW       = $clog2(ROWS),
    localparam int         CW       = $clog2(COLS),
    localparam int         FB_AW    = $clog2(ROWS * COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  snoop_word_t      in_word,
    input  logic [RW-1:0]    rd_row,
    output logic [7:0]       rd_page,
    output logic             disp_sel,
    output logic             fb_we,
    output logic             fb_sel,
    output logic [FB_AW-1:0] fb_addr,
    output logic [PIX_W-1:0] fb_data
);
    localparam logic [16:0] TBL_LO = {1'b0, IND_BASE};
    localparam logic [16:0] TBL_HI = TBL_LO + 17'(2 * ROWS);

    mode_state_e state_q, state_d;
    logic        disp_q, disp_d;
    logic [7:0]  mode_q, mode_d;
    logic [7:0]  tbl [ROWS];
    logic        tbl_we;
    logic [RW-1:0] tbl_idx;
    logic        tbl_hit, tbl_odd;
    logic [ADDR_W-1:0] waddr;

    assign waddr    = in_word.addr;
    assign rd_page  = tbl[rd_row];
    assign disp_sel = disp_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_DEFAULT;
            disp_q  <= 1'b0;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            disp_q  <= disp_d;
            mode_q  <= mode_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        disp_d  = disp_q;
        mode_d  = mode_q;
        tbl_we  = 1'b0;
        fb_we   = 1'b0;
        fb_sel  = disp_q;
        tbl_hit = ({1'b0, waddr} >= TBL_LO) && ({1'b0, waddr} < TBL_HI);
        tbl_odd = waddr[0];
        tbl_idx = RW'((waddr - IND_BASE) >> 1);
        fb_addr = FB_AW'(RW'(waddr[15:8] - PAGE0)) * FB_AW'(COLS)
                  + FB_AW'(waddr[CW-1:0]);
        fb_data = in_word.data[PIX_W-1:0];
        if (in_valid) begin
            if (tbl_hit && tbl_idx == '0 && !tbl_odd) begin
                if (in_word.data == 8'h00) begin
                    state_d = decode_mode(mode_q);
                end else begin
                    state_d = MS_DEFAULT;
                    tbl_we  = 1'b1;
                end
            end else if (tbl_hit && tbl_idx == '0) begin
                mode_d = in_word.data;
                if (state_q != MS_DEFAULT) state_d = decode_mode(in_word.data);
            end else if (tbl_hit) begin
                tbl_we = !tbl_odd && (state_q == MS_DEFAULT);
            end else begin
                unique case (state_q)
                    MS_DEFAULT: begin fb_we = 1'b1; fb_sel = disp_q;  end
                    MS_STORE:   begin fb_we = 1'b1; fb_sel = !disp_q; end
                    MS_SHOW:    fb_we = 1'b0;
                    MS_BLIND:   fb_we = 1'b0;
                endcase
            end
        end
        if (state_d == MS_SHOW && state_q != MS_SHOW) disp_d = !disp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) tbl[r] <= PAGE0 + 8'(r);
        end else if (tbl_we) begin
            tbl[tbl_idx] <= in_word.data;
        end
    end

    // R8: outside normal mode the shown buffer is never written
    assert_hold_display_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != MS_DEFAULT && fb_we) |-> (fb_sel != disp_q));
    // R10: arriving in the show state comes with a buffer swap
    assert_show_swaps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_SHOW && $past(state_q) != MS_SHOW) |-> (disp_q != $past(disp_q)));
    // R11: blind state writes nothing
    assert_blind_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_BLIND) |-> !fb_we);
endmodule

// File: rtl/snoop_scanout.sv
module snoop_scanout
    import snoop_fb_pkg::*;
#(
    parameter logic [7:0] PAGE0    = 8'h08,
    parameter int         ROWS     = 120,
    parameter int         COLS     = 8,
    parameter int         LINE_REP = 4,
    parameter int         H_FP     = 2,
    parameter int         H_SYNC   = 2,
    parameter int         H_BP     = 2,
    parameter int         V_FP     = 2,
    parameter int         V_SYNC   = 2,
    parameter int         V_BP     = 2,
    localparam int        RW       = $clog2(ROWS),
    localparam int        FB_DEPTH = ROWS * COLS,
    localparam int        FB_AW    = $clog2(FB_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fb_we,
    input  logic             fb_sel,
    input  logic [FB_AW-1:0] fb_addr,
    input  logic [PIX_W-1:0] fb_data,
    input  logic             disp_sel,
    output logic [RW-1:0]    rd_row,
    input  logic [7:0]       rd_page,
    output logic             vid_hsync,
    output logic             vid_vsync,
    output logic             vid_de,
    output logic [PIX_W-1:0] vid_pixel
);
    localparam int H_TOTAL  = COLS + H_FP + H_SYNC + H_BP;
    localparam int V_ACTIVE = ROWS * LINE_REP;
    localparam int V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int HW       = $clog2(H_TOTAL);
    localparam int VW       = $clog2(V_TOTAL);
    localparam logic [8:0] PAGE_END = 9'(PAGE0) + 9'(ROWS);

    logic [HW-1:0] hc;
    logic [VW-1:0] vc;
    logic h_act, v_act, hs, vs, pg_ok;
    logic [FB_AW-1:0] rd_addr;
    logic [1:0][PIX_W-1:0] bank_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc <= '0;
            vc <= '0;
        end else if (hc == HW'(H_TOTAL - 1)) begin
            hc <= '0;
            vc <= (vc == VW'(V_TOTAL - 1)) ? '0 : vc + VW'(1);
        end else begin
            hc <= hc + HW'(1);
        end
    end

    always_comb begin
        h_act   = hc < HW'(COLS);
        v_act   = vc < VW'(V_ACTIVE);
        hs      = (hc >= HW'(COLS + H_FP)) && (hc < HW'(COLS + H_FP + H_SYNC));
        vs      = (vc >= VW'(V_ACTIVE + V_FP)) && (vc < VW'(V_ACTIVE + V_FP + V_SYNC));
        rd_row  = v_act ? RW'(vc / VW'(LINE_REP)) : '0;
        pg_ok   = (rd_page >= PAGE0) && ({1'b0, rd_page} < PAGE_END);
        rd_addr = FB_AW'(RW'(rd_page - PAGE0)) * FB_AW'(COLS) + FB_AW'(hc);
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [PIX_W-1:0] mem [FB_DEPTH];
        always_ff @(posedge clk) begin
            if (fb_we && fb_sel == 1'(b)) mem[fb_addr] <= fb_data;
        end
        assign bank_rd[b] = mem[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vid_hsync <= 1'b0;
            vid_vsync <= 1'b0;
            vid_de    <= 1'b0;
            vid_pixel <= '0;
        end else begin
            vid_hsync <= hs;
            vid_vsync <= vs;
            vid_de    <= h_act && v_act;
            vid_pixel <= (h_act && v_act && pg_ok) ? bank_rd[disp_sel] : '0;
        end
    end

    // R4: the active flag never overlaps a sync pulse
    assert_de_clear_of_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vid_de |-> !(vid_hsync || vid_vsync));
endmodule

// File: rtl/snoop_fb_ctrl.sv
module snoop_fb_ctrl
    import snoop_fb_pkg::*;
#(
    parameter logic [15:0] IND_BASE = 16'h0100,
    parameter logic [7:0]  PAGE0    = 8'h08,
    parameter int          ROWS     = 120,
    parameter int          COLS     = 8,
    parameter int          LINE_REP = 4,
    parameter int          FIFO_AW  = 3
) (
    input  logic        host_clk,
    input  logic        host_rst_n,
    input  logic [15:0] host_addr,
    input  logic [7:0]  host_data,
    input  logic        host_we_n,
    input  logic        vid_clk,
    input  logic        vid_rst_n,
    output logic        vid_hsync,
    output logic        vid_vsync,
    output logic        vid_de,
    output logic [5:0]  vid_pixel
);
    localparam int RW    = $clog2(ROWS);
    localparam int FB_AW = $clog2(ROWS * COLS);
    localparam int WW    = $bits(snoop_word_t);

    logic        cap_valid, q_full, q_empty;
    snoop_word_t cap_word, q_word;
    logic [WW-1:0] q_rdata;
    logic [RW-1:0] rd_row;
    logic [7:0]    rd_page;
    logic          disp_sel, fb_we, fb_sel;
    logic [FB_AW-1:0] fb_addr;
    logic [PIX_W-1:0] fb_data;

    assign q_word = snoop_word_t'(q_rdata);

    snoop_capture #(.IND_BASE(IND_BASE), .PAGE0(PAGE0), .ROWS(ROWS), .COLS(COLS)) u_cap (
        .clk(host_clk), .rst_n(host_rst_n), .addr(host_addr), .data(host_data),
        .we_n(host_we_n), .cap_valid(cap_valid), .cap_word(cap_word));

    snoop_async_fifo #(.DW(WW), .AW(FIFO_AW)) u_fifo (
        .wclk(host_clk), .wrst_n(host_rst_n), .push(cap_valid), .wdata(cap_word),
        .full(q_full), .rclk(vid_clk), .rrst_n(vid_rst_n), .pop(!q_empty),
        .rdata(q_rdata), .empty(q_empty));

    snoop_mode_ctrl #(.IND_BASE(IND_BASE), .PAGE0(PAGE0), .ROWS(ROWS), .COLS(COLS)) u_mode (
        .clk(vid_clk), .rst_n(vid_rst_n), .in_valid(!q_empty), .in_word(q_word),
        .rd_row(rd_row), .rd_page(rd_page), .disp_sel(disp_sel), .fb_we(fb_we),
        .fb_sel(fb_sel), .fb_addr(fb_addr), .fb_data(fb_data));

    snoop_scanout #(.PAGE0(PAGE0), .ROWS(ROWS), .COLS(COLS), .LINE_REP(LINE_REP)) u_scan (
        .clk(vid_clk), .rst_n(vid_rst_n), .fb_we(fb_we), .fb_sel(fb_sel),
        .fb_addr(fb_addr), .fb_data(fb_data), .disp_sel(disp_sel), .rd_row(rd_row),
        .rd_page(rd_page), .vid_hsync(vid_hsync), .vid_vsync(vid_vsync),
        .vid_de(vid_de), .vid_pixel(vid_pixel));
endmodule

// File: tb/snoop_fb_ctrl_test.sv
module snoop_fb_ctrl_test;
    localparam int ROWS = 120, COLS = 8, REP = 4;
    localparam int PAGE0 = 8;
    localparam int V_ACTIVE = ROWS * REP;
    localparam int H_TOTAL = COLS + 6;
    localparam int V_TOTAL = V_ACTIVE + 6;
    localparam int FB_DEPTH = ROWS * COLS;

    logic host_clk = 0, vid_clk = 0;
    logic host_rst_n = 0, vid_rst_n = 0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_data = '0;
    logic        host_we_n = 1;
    logic vid_hsync, vid_vsync, vid_de;
    logic [5:0] vid_pixel;

    always #10 host_clk = ~host_clk;
    always #7  vid_clk  = ~vid_clk;

    snoop_fb_ctrl uut (
        .host_clk(host_clk), .host_rst_n(host_rst_n), .host_addr(host_addr),
        .host_data(host_data), .host_we_n(host_we_n), .vid_clk(vid_clk),
        .vid_rst_n(vid_rst_n), .vid_hsync(vid_hsync), .vid_vsync(vid_vsync),
        .vid_de(vid_de), .vid_pixel(vid_pixel));

    int checks = 0, failures = 0;

    // requirement-level model
    logic [5:0] mb [2][FB_DEPTH];
    logic [7:0] mt [ROWS];
    logic [7:0] mmode = 0;
    int  mst = 0;   // 0 default, 1 store, 2 show, 3 blind
    bit  mdisp = 0;

    // scoreboard
    logic [5:0] expq [$];
    string cur_tag;
    bit pending = 0, armed = 0, prev_vs = 0;
    int mism, pos, fpos;
    logic [5:0] fa, fe, e;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic check(input bit ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    function automatic int dec(input logic [7:0] m);
        return (m == 8'h01) ? 1 : ((m == 8'h02) ? 2 : 3);
    endfunction

    task automatic enter(input int ns);
        if (ns == 2 && mst != 2) mdisp = !mdisp;
        mst = ns;
    endtask

    task automatic model_apply(input logic [15:0] a, input logic [7:0] d);
        int idx;
        if (a >= 16'h0100 && int'(a) < 16'h0100 + 2 * ROWS) begin
            idx = (int'(a) - 16'h0100) / 2;
            if (idx == 0 && !a[0]) begin
                if (d == 0) enter(dec(mmode));
                else begin enter(0); mt[0] = d; end
            end else if (idx == 0) begin
                mmode = d;
                if (mst != 0) enter(dec(d));
            end else if (!a[0] && mst == 0) mt[idx] = d;
        end else if (int'(a[15:8]) >= PAGE0 && int'(a[15:8]) < PAGE0 + ROWS && int'(a[7:0]) < COLS) begin
            idx = (int'(a[15:8]) - PAGE0) * COLS + int'(a[7:0]);
            if (mst == 0) mb[mdisp][idx] = d[5:0];
            else if (mst == 1) mb[!mdisp][idx] = d[5:0];
        end
    endtask

    // driver: one bus cycle per write, strobe optionally held inactive
    task automatic host_write(input logic [15:0] a, input logic [7:0] d, input bit en);
        @(negedge host_clk);
        host_addr = a; host_data = d; host_we_n = !en;
        @(negedge host_clk);
        host_we_n = 1;
        if (en) model_apply(a, d);
    endtask

    task automatic fill(input int seed);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                host_write({8'(PAGE0 + r), 8'(c)}, {2'b11, 6'((r * 5 + c * 3 + seed) & 63)}, 1);
    endtask

    task automatic expect_frame(input string tag);
        repeat (20) @(negedge host_clk);
        expq.delete();
        for (int ln = 0; ln < V_ACTIVE; ln++) begin
            for (int c = 0; c < COLS; c++) begin
                int pg;
                pg = int'(mt[ln / REP]);
                if (pg >= PAGE0 && pg < PAGE0 + ROWS)
                    expq.push_back(mb[mdisp][(pg - PAGE0) * COLS + c]);
                else
                    expq.push_back(6'd0);
            end
        end
        cur_tag = tag;
        pending = 1;
        wait (pending == 0);
    endtask

    // monitor: starts on a vsync fall, compares every active pixel of the next frame
    always @(negedge vid_clk) begin
        if (pending) begin
            if (!armed) begin
                if (prev_vs && !vid_vsync) begin armed = 1; mism = 0; pos = 0; end
            end else if (vid_de) begin
                e = expq.pop_front();
                if (vid_pixel !== e) begin
                    if (mism == 0) begin fa = vid_pixel; fe = e; fpos = pos; end
                    mism++;
                end
                pos++;
                if (expq.size() == 0) begin
                    checks++;
                    if (mism != 0) begin
                        failures++;
                        $display("FAIL %s line %0d col %0d (%0d bad pixels) actual=%0d expected=%0d",
                                 cur_tag, fpos / COLS, fpos % COLS, mism, fa, fe);
                    end
                    armed = 0;
                    pending = 0;
                end
            end
        end
        prev_vs = vid_vsync;
    end

    function automatic bit sel(input bit v);
        return v ? vid_vsync : vid_hsync;
    endfunction

    task automatic measure(input bit v, output int period, output int width);
        bit p, cur, hi;
        p = sel(v);
        forever begin
            @(negedge vid_clk);
            cur = sel(v);
            if (!p && cur) break;
            p = cur;
        end
        period = 0; width = 1; hi = 1; p = 1;
        forever begin
            @(negedge vid_clk);
            period++;
            cur = sel(v);
            if (hi && cur) width++;
            if (!cur) hi = 0;
            if (!p && cur) break;
            p = cur;
        end
    endtask

    initial begin : watchdog
        int n;
        n = 0;
        forever begin
            @(posedge host_clk);
            n++;
            if (n >= 180000) begin
                failures++;
                $display("FAIL watchdog (all requirements) actual=%0d expected=<%0d cycles", n, n);
                summary();
                $finish;
            end
        end
    end

    initial begin : main
        int per, wid;
        for (int r = 0; r < ROWS; r++) mt[r] = 8'(PAGE0 + r);
        repeat (6) @(negedge vid_clk);
        check({vid_de, vid_hsync, vid_vsync, vid_pixel} == 9'd0, "R5 outputs idle in reset",
              int'({vid_de, vid_hsync, vid_vsync, vid_pixel}), 0);
        @(negedge host_clk);
        host_rst_n = 1;
        vid_rst_n = 1;

        measure(0, per, wid);
        check(per == H_TOTAL, "R4 hsync period", per, H_TOTAL);
        check(wid == 2, "R4 hsync width", wid, 2);
        measure(1, per, wid);
        check(per == H_TOTAL * V_TOTAL, "R4 vsync period", per, H_TOTAL * V_TOTAL);

        // R1 R2 R3 R5: full fill, identity table, four-line repeat
        fill(0);
        expect_frame("R1/R2/R3/R5 identity picture");

        // R1 ignored writes, R13 ordering
        host_write(16'h0800, 8'h3F, 0);
        host_write({8'(PAGE0), 8'(COLS)}, 8'h3F, 1);
        host_write(16'h8000, 8'h3F, 1);
        host_write(16'h0801, 8'h11, 1);
        host_write(16'h0801, 8'h22, 1);
        expect_frame("R1/R13 strobe, range and order");

        // R6 remap and out-of-range page, R12 non-zero entry 0
        host_write(16'h0106, 8'(PAGE0 + 10), 1);
        host_write(16'h010E, 8'h90, 1);
        host_write(16'h0100, 8'(PAGE0 + 1), 1);
        expect_frame("R6/R12 remapped rows");

        // R7 R8 R9 store-only
        host_write(16'h0101, 8'h01, 1);
        host_write(16'h0100, 8'h00, 1);
        host_write(16'h0104, 8'(PAGE0 + 50), 1);
        fill(17);
        expect_frame("R7/R8/R9 store holds picture");

        // R10 show flips, pixel writes ignored
        host_write(16'h0101, 8'h02, 1);
        host_write(16'h0802, 8'h3F, 1);
        expect_frame("R10 show staged buffer");

        // R11 blind
        host_write(16'h0101, 8'h05, 1);
        host_write(16'h0803, 8'h2A, 1);
        host_write(16'h0102, 8'(PAGE0 + 99), 1);
        host_write(16'h0100, 8'h00, 1);
        host_write(16'h0805, 8'h2B, 1);
        expect_frame("R11 blind ignores writes");

        // R12 return to default, writes visible again
        host_write(16'h0100, 8'(PAGE0), 1);
        host_write(16'h0804, 8'h15, 1);
        host_write(16'h0102, 8'(PAGE0 + 20), 1);
        expect_frame("R12 back to default");

        // R7 R10 second round: stage one cell then flip back
        host_write(16'h0101, 8'h01, 1);
        host_write(16'h0100, 8'h00, 1);
        host_write(16'h0806, 8'h07, 1);
        host_write(16'h0101, 8'h02, 1);
        expect_frame("R7/R10 second flip");

        summary();
        $finish;
    end
endmodule